// File: doc/BRIEF.md
# Configurable Local Wake Detector

This block watches three local wake inputs while the host device sleeps and raises a single wake request when one of them meets its configured condition. Each input passes through a two-flop synchronizer. Each input then has its own detection mode. A mode can be a rising edge, a falling edge, either edge, a qualified pulse whose width must fall inside a window, or cyclic sensing. In cyclic sensing, a sense-supply strobe is pulsed periodically and the level sampled at the end of each strobe is compared with the previous sample.

Each pin has a sticky status flag. A flag clears only when a 1 is written to it. A per-pin mask takes a flag out of the wake request. Pin 2 can also be switched into a direct-drive role. In that role its synchronized level becomes the enable of one selected output channel, and it stops acting as a wake source. All settings sit in four 8-bit registers behind a simple write port with a combinational read port.

Top module: `lwake_detector`

## Requirements
- R1: After reset, register 0 reads 0x1B, register 1 reads 0x03, register 2 reads 0x00 and register 3 reads 0x13. Also after reset, wake_req and sense_en are low. Mode codes are 0 off, 1 rising, 2 falling, 3 either edge, 4 pulse and 5 cyclic. Codes 6 and 7 behave as off.
- R2: In rising mode, a low-to-high change of a pin sets that pin's flag and a high-to-low change does not. The flag is visible no later than the third clock edge after the input changes.
- R3: In falling mode, a high-to-low change sets the flag and a low-to-high change does not.
- R4: In either-edge mode, each change of the pin sets the flag.
- R5: In pulse mode, the flag is set when the input returns low after having been high for at least MIN_PULSE and at most MAX_PULSE cycles. Shorter or longer pulses are ignored. With the defaults, that range is 4 to 16 cycles.
- R6: While asleep with any armed pin in cyclic mode, sense_en is high for on+1 cycles of every period of (per+1)*PERIOD_UNIT cycles. Here register 3 holds per in bits [3:0] and on in bits [7:4]. The level is sampled in the last high cycle. The first sample sets no flag, and a later sample that differs from the one before sets the flag. When the device is awake, sense_en stays low.
- R7: Register 1 holds the pin 2 mode in bits [2:0], the direct-drive enable in bit 3 and the channel select in bits [5:4]. Register 0 holds the pin 0 mode in bits [2:0] and the pin 1 mode in bits [5:3]. With direct drive on, drv_en[select] follows the synchronized pin 2 level, the other drv_en bits stay low, and pin 2 sets no flag.
- R8: Register 2 bits [2:0] are the sticky flags of pins 0 to 2. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R9: Register 2 bits [5:3] are per-pin masks. wake_req is high exactly when some flag is set and not masked. A masked flag still reads back as set.
- R10: No flag is set while sleep is low, and no flag is set for a pin whose mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | High while the device sleeps; arms detection |
| wake_in | input | 3 | Asynchronous local wake inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index 0..3 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| wake_req | output | 1 | OR of unmasked status flags |
| sense_en | output | 1 | Periodic sense-supply strobe for cyclic sensing |
| drv_en | output | NUM_DRV | Direct-drive channel enables |

## Verification
The pulse window is probed at both of its edges with widths of 3, 4, 16 and 17 cycles. A counter that is off by one, or that does not saturate, would accept a pulse that should be rejected or reject one that should be accepted. In cyclic mode the bench holds the input still over several samples, then changes it. A design that compares against an invalid first sample would wake with no change, and one that drops the stored sample would never wake. Direct drive is checked both ways: an implementation that still routed pin 2 into its flag, or that decoded the wrong channel, shows up at drv_en and in register 2. Flags are also checked against partial clears, masking, the awake state and the off mode, where a leaky design would raise wake_req.

// File: rtl/lwake_pkg.sv
package lwake_pkg;
   localparam int NUM_PINS = 3;
   localparam int REG_W    = 8;

   typedef enum logic [2:0] {
      WM_OFF    = 3'd0,
      WM_RISE   = 3'd1,
      WM_FALL   = 3'd2,
      WM_BOTH   = 3'd3,
      WM_PULSE  = 3'd4,
      WM_CYCLIC = 3'd5
   } wake_mode_e;

   localparam logic [1:0] A_MODE01 = 2'd0;
   localparam logic [1:0] A_MODE2  = 2'd1;
   localparam logic [1:0] A_STAT   = 2'd2;
   localparam logic [1:0] A_CYC    = 2'd3;

   localparam logic [3:0] PER_RST = 4'd3;
   localparam logic [3:0] ON_RST  = 4'd1;
endpackage

// File: rtl/lwake_sync.sv
module lwake_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lwake_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lwake_cyc_timer.sv
module lwake_cyc_timer #(
   parameter int PERIOD_UNIT = 4,
   parameter int CODE_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] per_code,
   input  logic [CODE_W-1:0] on_code,
   output logic              sense_en,
   output logic              smp_stb
);
   localparam int TW = $clog2((2**CODE_W) * PERIOD_UNIT + 1);

   if (PERIOD_UNIT < 1) begin : g_bad_unit
      $error("lwake_cyc_timer: PERIOD_UNIT must be at least 1");
   end

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] period_len;
   logic [TW-1:0] on_len;
   logic [TW-1:0] on_eff;

   always_comb begin
      period_len = (TW'(per_code) + TW'(1)) * TW'(PERIOD_UNIT);
      on_len     = TW'(on_code) + TW'(1);
      on_eff     = (on_len > period_len) ? period_len : on_len;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!run)                     cnt_q <= '0;
      else if (cnt_q >= period_len - 1)  cnt_q <= '0;
      else                               cnt_q <= cnt_q + TW'(1);
   end

   assign sense_en = run && (cnt_q < on_eff);
   assign smp_stb  = run && (cnt_q == on_eff - TW'(1));
endmodule

// File: rtl/lwake_pin_det.sv
module lwake_pin_det
   import lwake_pkg::*;
#(
   parameter int MIN_PULSE = 4,
   parameter int MAX_PULSE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  wake_mode_e mode,
   input  logic       lvl,
   input  logic       smp_stb,
   output logic       hit
);
   localparam int          CW    = $clog2(MAX_PULSE + 2);
   localparam logic [CW-1:0] MIN_C = CW'(MIN_PULSE);
   localparam logic [CW-1:0] MAX_C = CW'(MAX_PULSE);
   localparam logic [CW-1:0] SAT_C = CW'(MAX_PULSE + 1);

   logic          prev_q;
   logic [CW-1:0] width_q;
   logic          smp_q;
   logic          smp_vld_q;
   logic          rise, fall, pulse_ok, cyc_diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         width_q   <= '0;
         smp_q     <= 1'b0;
         smp_vld_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (!lvl)                width_q <= '0;
         else if (width_q != SAT_C) width_q <= width_q + CW'(1);
         if (arm && mode == WM_CYCLIC) begin
            if (smp_stb) begin
               smp_q     <= lvl;
               smp_vld_q <= 1'b1;
            end
         end else begin
            smp_vld_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rise     = lvl && !prev_q;
      fall     = !lvl && prev_q;
      pulse_ok = fall && (width_q >= MIN_C) && (width_q <= MAX_C);
      cyc_diff = smp_stb && smp_vld_q && (lvl != smp_q);
      case (mode)
         WM_RISE:   hit = arm && rise;
         WM_FALL:   hit = arm && fall;
         WM_BOTH:   hit = arm && (rise || fall);
         WM_PULSE:  hit = arm && pulse_ok;
         WM_CYCLIC: hit = arm && cyc_diff;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/lwake_detector.sv
module lwake_detector
   import lwake_pkg::*;
#(
   parameter int MIN_PULSE   = 4,
   parameter int MAX_PULSE   = 16,
   parameter int PERIOD_UNIT = 4,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_DRV     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep,
   input  logic [2:0]         wake_in,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               wake_req,
   output logic               sense_en,
   output logic [NUM_DRV-1:0] drv_en
);
   localparam int DD_PIN = NUM_PINS - 1;

   if (NUM_DRV < 1 || NUM_DRV > 4) begin : g_bad_drv
      $error("lwake_detector: NUM_DRV must be 1..4");
   end
   if (MIN_PULSE < 1 || MAX_PULSE < MIN_PULSE) begin : g_bad_pulse
      $error("lwake_detector: need 1 <= MIN_PULSE <= MAX_PULSE");
   end

   wake_mode_e          mode_q [NUM_PINS];
   logic                dd_en_q;
   logic [1:0]          dd_sel_q;
   logic [NUM_PINS-1:0] mask_q;
   logic [NUM_PINS-1:0] status_q;
   logic [3:0]          per_q;
   logic [3:0]          on_q;

   logic [NUM_PINS-1:0] lvl;
   logic [NUM_PINS-1:0] arm;
   logic [NUM_PINS-1:0] hit;
   logic [NUM_PINS-1:0] clr;
   logic                any_cyc;
   logic                smp_stb;
   logic                wr_stat;

   lwake_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(wake_in), .q(lvl)
   );

   always_comb begin
      any_cyc = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         arm[i] = sleep && !(i == DD_PIN && dd_en_q);
         if (arm[i] && mode_q[i] == WM_CYCLIC) any_cyc = 1'b1;
      end
   end

   lwake_cyc_timer #(.PERIOD_UNIT(PERIOD_UNIT), .CODE_W(4)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(any_cyc), .per_code(per_q),
      .on_code(on_q), .sense_en(sense_en), .smp_stb(smp_stb)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      lwake_pin_det #(.MIN_PULSE(MIN_PULSE), .MAX_PULSE(MAX_PULSE)) u_det (
         .clk(clk), .rst_n(rst_n), .arm(arm[p]), .mode(mode_q[p]),
         .lvl(lvl[p]), .smp_stb(smp_stb), .hit(hit[p])
      );
   end

   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign clr     = wr_stat ? reg_wdata[NUM_PINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PINS; i++) mode_q[i] <= WM_BOTH;
         dd_en_q  <= 1'b0;
         dd_sel_q <= 2'd0;
         mask_q   <= '0;
         per_q    <= PER_RST;
         on_q     <= ON_RST;
      end else if (reg_wr) begin
         case (reg_addr)
            A_MODE01: begin
               mode_q[0] <= wake_mode_e'(reg_wdata[2:0]);
               mode_q[1] <= wake_mode_e'(reg_wdata[5:3]);
            end
            A_MODE2: begin
               mode_q[2] <= wake_mode_e'(reg_wdata[2:0]);
               dd_en_q   <= reg_wdata[3];
               dd_sel_q  <= reg_wdata[5:4];
            end
            A_STAT:  mask_q <= reg_wdata[5:3];
            default: begin
               per_q <= reg_wdata[3:0];
               on_q  <= reg_wdata[7:4];
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr) | hit;
   end

   assign wake_req = |(status_q & ~mask_q);

   always_comb begin
      case (reg_addr)
         A_MODE01: reg_rdata = {2'b00, mode_q[1], mode_q[0]};
         A_MODE2:  reg_rdata = {2'b00, dd_sel_q, dd_en_q, mode_q[2]};
         A_STAT:   reg_rdata = {2'b00, mask_q, status_q};
         default:  reg_rdata = {on_q, per_q};
      endcase
   end

   for (genvar j = 0; j < NUM_DRV; j++) begin : g_drv
      assign drv_en[j] = dd_en_q && (dd_sel_q == 2'(j)) && lvl[DD_PIN];
   end
endmodule

// File: rtl/lwake_detector_chk.sv
module lwake_detector_chk #(
   parameter int NUM_DRV = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sleep,
   input logic               reg_wr,
   input logic [1:0]         reg_addr,
   input logic [7:0]         reg_wdata,
   input logic [2:0]         status,
   input logic [2:0]         mask,
   input logic               dd_en,
   input logic               wake_req,
   input logic               sense_en,
   input logic               smp_stb,
   input logic [NUM_DRV-1:0] drv_en
);
   // R8: a flag falls only when a write of 1 to its bit cleared it
   assert_sticky_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(status) & ~status) &
        ~(($past(reg_wr) && $past(reg_addr) == 2'd2) ? $past(reg_wdata[2:0]) : 3'b000)) == 3'b000));

   // R10: nothing new is flagged while awake
   assert_awake_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sleep) |-> ($countones(status) <= $countones($past(status))));

   // R7: pin 2 in direct drive never raises its flag
   assert_dd_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dd_en) |-> !$rose(status[2]));

   // R7: at most one channel is driven
   assert_drv_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_en));

   // R6: the sample falls inside the sense window
   assert_sample_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> sense_en);

   // R6: no strobe while awake
   assert_no_sense_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep |-> !sense_en);

   // R9: no request without an unmasked flag
   assert_req_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~mask) == 3'b000) |-> !wake_req);
endmodule

bind lwake_detector lwake_detector_chk #(.NUM_DRV(NUM_DRV)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep(sleep), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status_q),
   .mask(mask_q), .dd_en(dd_en_q), .wake_req(wake_req),
   .sense_en(sense_en), .smp_stb(smp_stb), .drv_en(drv_en)
);

// File: tb/lwake_detector_tb_top.sv
module lwake_detector_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep = 1'b0;
   logic [2:0] wake_in = 3'b000;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       wake_req;
   logic       sense_en;
   logic [3:0] drv_en;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   lwake_detector dut_i (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .wake_in(wake_in),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .wake_req(wake_req), .sense_en(sense_en),
      .drv_en(drv_en)
   );

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic chk_stat(input string req, input logic [2:0] exp);
      logic [7:0] d;
      rd(2'd2, d);
      chk(req, 32'(d[2:0]), 32'(exp));
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(2'd0, d); chk("R1 reg0", 32'(d), 32'h1B);
      rd(2'd1, d); chk("R1 reg1", 32'(d), 32'h03);
      rd(2'd2, d); chk("R1 reg2", 32'(d), 32'h00);
      rd(2'd3, d); chk("R1 reg3", 32'(d), 32'h13);
      chk("R1 wake_req", 32'(wake_req), 0);
      chk("R1 sense_en", 32'(sense_en), 0);
   endtask

   task automatic t_awake;
      sleep = 1'b0;
      wake_in[0] = 1'b1; tick(5);
      chk_stat("R10 awake edge ignored", 3'b000);
      wake_in[0] = 1'b0; tick(5);
      chk_stat("R10 awake edge ignored", 3'b000);
   endtask

   task automatic t_both;
      sleep = 1'b1; tick(2);
      wake_in[1] = 1'b1; tick(4);
      chk_stat("R4 rise flag", 3'b010);
      chk("R9 wake_req", 32'(wake_req), 1);
      wr(2'd2, 8'h02);
      chk_stat("R8 clear", 3'b000);
      chk("R9 wake_req low", 32'(wake_req), 0);
      wake_in[1] = 1'b0; tick(4);
      chk_stat("R4 fall flag", 3'b010);
      wr(2'd2, 8'h02);
   endtask

   task automatic t_rise;
      wr(2'd0, 8'h19);
      wake_in[0] = 1'b1; tick(4);
      chk_stat("R2 rise flag", 3'b001);
      wr(2'd2, 8'h01);
      wake_in[0] = 1'b0; tick(4);
      chk_stat("R2 fall ignored", 3'b000);
   endtask

   task automatic t_fall;
      wr(2'd0, 8'h1A);
      wake_in[0] = 1'b1; tick(4);
      chk_stat("R3 rise ignored", 3'b000);
      wake_in[0] = 1'b0; tick(4);
      chk_stat("R3 fall flag", 3'b001);
      wr(2'd2, 8'h01);
   endtask

   task automatic t_sticky_mask;
      logic [7:0] d;
      wake_in[1] = 1'b1; tick(4);
      tick(10);
      chk_stat("R8 sticky", 3'b010);
      wr(2'd2, 8'h01);
      chk_stat("R8 partial clear", 3'b010);
      wr(2'd2, 8'h10);
      rd(2'd2, d);
      chk("R9 masked readback", 32'(d), 32'h12);
      chk("R9 masked req", 32'(wake_req), 0);
      wr(2'd2, 8'h00);
      chk("R9 unmasked req", 32'(wake_req), 1);
      wr(2'd2, 8'h02);
      wake_in[1] = 1'b0; tick(4);
      wr(2'd2, 8'h07);
   endtask

   task automatic t_off;
      wr(2'd0, 8'h00);
      wake_in[0] = 1'b1; tick(4);
      wake_in[0] = 1'b0; tick(4);
      chk_stat("R10 off mode", 3'b000);
   endtask

   task automatic pulse(input int w, input string req, input logic [2:0] exp);
      @(negedge clk);
      wake_in[0] = 1'b1;
      tick(w);
      wake_in[0] = 1'b0;
      tick(6);
      chk_stat(req, exp);
      wr(2'd2, 8'h01);
   endtask

   task automatic t_pulse;
      wr(2'd0, 8'h04);
      pulse(3,  "R5 short pulse", 3'b000);
      pulse(4,  "R5 min pulse",   3'b001);
      pulse(16, "R5 max pulse",   3'b001);
      pulse(17, "R5 long pulse",  3'b000);
   endtask

   task automatic t_cyclic;
      int hi;
      wr(2'd3, 8'h21);
      wr(2'd0, 8'h05);
      hi = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (sense_en) hi++;
      end
      chk("R6 on cycles", 32'(hi), 6);
      tick(30);
      chk_stat("R6 static level", 3'b000);
      wake_in[0] = 1'b1; tick(20);
      chk_stat("R6 changed level", 3'b001);
      wr(2'd2, 8'h01);
      tick(20);
      chk_stat("R6 steady high", 3'b000);
      sleep = 1'b0;
      hi = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (sense_en) hi++;
      end
      chk("R6 awake no strobe", 32'(hi), 0);
      wake_in[0] = 1'b0;
      sleep = 1'b1;
      wr(2'd0, 8'h00);
   endtask

   task automatic t_dd;
      wr(2'd1, 8'h2B);
      wake_in[2] = 1'b1; tick(3);
      chk("R7 drive on", 32'(drv_en), 32'h4);
      wake_in[2] = 1'b0; tick(3);
      chk("R7 drive off", 32'(drv_en), 32'h0);
      chk_stat("R7 no flag", 3'b000);
      wr(2'd1, 8'h03);
      wake_in[2] = 1'b1; tick(4);
      chk_stat("R7 wake again", 3'b100);
      chk("R7 no drive", 32'(drv_en), 32'h0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_awake();
      t_both();
      t_rise();
      t_fall();
      t_sticky_mask();
      t_off();
      t_pulse();
      t_cyclic();
      t_dd();
      tick(2);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule